// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block fetches one instruction at a time, one byte per memory transfer, into a 48-bit instruction register. Each byte is read from the 20-bit location formed by shifting the 16-bit code segment value left by four bits and adding the 16-bit instruction pointer. The first byte read is the opcode. It is presented to an external length table, and the table's answer sets how many more bytes are read.

Bytes are packed into the instruction register in the order they arrive, starting from the most significant byte, with no byte swapping. The instruction pointer steps once for every byte accepted. When the last byte has arrived, the sequencer raises a one-cycle valid pulse. It then waits for the executing logic to signal completion before it starts the next fetch. While idle between instructions it can take a new instruction pointer, or it can stop permanently on a halt request.

Top module: `ifetch_seq`

## Requirements
- R1: During and after reset, mem_req_o, valid_o and halted_o are 0, ip_o is 0 and ir_o is 0. The sequencer then starts fetching on its own.
- R2: Whenever mem_req_o is 1, mem_addr_o equals (cs_i * 16 + ip_o) modulo 2^20.
- R3: The opcode lands in ir_o[47:40]. Byte k of the instruction (k = 1..5 after the opcode) lands in ir_o[47-8k -: 8], in fetch order, with no byte reordering.
- R4: The table length len_i (3 bits, sampled while the opcode is held on opc_o) gives the total byte count: 0 counts as 1, 7 counts as 6, and 1..6 are used as they are. Exactly that many bytes are read, and len_o reports the count with valid_o.
- R5: Byte slots of ir_o beyond the instruction length read as zero when valid_o is 1.
- R6: ip_o rises by one, modulo 2^16, for each byte accepted (a cycle with mem_req_o and mem_rdy_i both 1). After an instruction, ip_o points to the byte just past it.
- R7: A request with mem_rdy_i at 0 stays asserted with an unchanged address until mem_rdy_i is 1.
- R8: valid_o is a one-cycle pulse. No request is issued from that pulse until one cycle after exec_done_i is seen.
- R9: jump_i loads jump_ip_i into ip_o only while the sequencer is idle between instructions. During a fetch it has no effect on ip_o or on the addresses.
- R10: halt_i seen while idle stops all fetching. halted_o then stays at 1, mem_req_o stays at 0 and ip_o holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 16 | Code segment value |
| jump_i | input | 1 | Load a new instruction pointer (idle only) |
| jump_ip_i | input | 16 | Instruction pointer value to load |
| halt_i | input | 1 | Stop fetching (sampled while idle) |
| exec_done_i | input | 1 | Execution of the current instruction has finished |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 20 | Byte read address |
| mem_rdy_i | input | 1 | Read data valid, completes the request |
| mem_data_i | input | 8 | Read data byte |
| opc_o | output | 8 | Opcode byte presented to the length table |
| len_i | input | 3 | Length returned by the table |
| ir_o | output | 48 | Assembled instruction, first byte in the top bits |
| len_o | output | 3 | Instruction length in bytes |
| ip_o | output | 16 | Instruction pointer |
| valid_o | output | 1 | One-cycle pulse when an instruction is complete |
| halted_o | output | 1 | Sequencer has stopped |

## Verification
The case hardest to reach from the ports is a fetch that crosses the top of the pointer range: ip_o has to wrap from FFFFh to 0000h partway through an instruction, while the segment sum also wraps past the top of the 20-bit space. The stimulus gets there by loading the pointer near FFFFh and the segment at FFFFh through the idle-time jump, then running several instructions with random lengths. Random memory stalls and jump pulses during fetches are mixed in, so the address-hold rule and the rule that a jump mid-fetch has no effect are exercised on every length, including the lengths that are clamped.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_OPR,
    ST_VALID,
    ST_HALT
  } fetch_state_e;
endpackage

// File: rtl/ifetch_len.sv
module ifetch_len #(
  parameter int MAX_BYTES = 6,
  parameter int LEN_W     = 3
) (
  input  logic [LEN_W-1:0] raw_i,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    if (raw_i == '0)                       len_o = LEN_W'(1);
    else if (int'(raw_i) > MAX_BYTES)      len_o = LEN_W'(MAX_BYTES);
    else                                   len_o = raw_i;
  end
endmodule

// File: rtl/ifetch_addr.sv
module ifetch_addr #(
  parameter int SEG_W  = 16,
  parameter int IP_W   = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [IP_W-1:0]   ip_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] seg_base, ip_ext;

  assign seg_base = ADDR_W'(seg_i) << SHIFT;
  assign ip_ext   = ADDR_W'(ip_i);
  assign addr_o   = seg_base + ip_ext;
endmodule

// File: rtl/ifetch_ir.sv
module ifetch_ir #(
  parameter int MAX_BYTES = 6,
  parameter int BYTE_W    = 8,
  parameter int SLOT_W    = 3,
  localparam int IR_W     = MAX_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [IR_W-1:0]   ir_o
);
  // slot 0 occupies the top byte; later slots go downward
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q <= '0;
      else if (clr_i)                               slot_q <= '0;
      else if (wr_i && slot_i == SLOT_W'(k))        slot_q <= byte_i;
    end
    assign ir_o[IR_W-1-k*BYTE_W -: BYTE_W] = slot_q;
  end

  p_slot_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> int'(slot_i) < MAX_BYTES);
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifetch_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int LEN_W     = 3,
  parameter int SEG_W     = 16,
  parameter int IP_W      = 16,
  parameter int ADDR_W    = 20,
  parameter int BYTE_W    = 8,
  localparam int IR_W     = MAX_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEG_W-1:0]  cs_i,
  input  logic              jump_i,
  input  logic [IP_W-1:0]   jump_ip_i,
  input  logic              halt_i,
  input  logic              exec_done_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rdy_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic [BYTE_W-1:0] opc_o,
  input  logic [LEN_W-1:0]  len_i,
  output logic [IR_W-1:0]   ir_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [IP_W-1:0]   ip_o,
  output logic              valid_o,
  output logic              halted_o
);
  fetch_state_e     state_q;
  logic [IP_W-1:0]  ip_q;
  logic [LEN_W-1:0] cnt_q, len_q, len_c, slot_c;
  logic             valid_q, acc_c, clr_c;

  ifetch_len #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_len (
    .raw_i(len_i), .len_o(len_c)
  );

  ifetch_addr #(.SEG_W(SEG_W), .IP_W(IP_W), .ADDR_W(ADDR_W), .SHIFT(4)) u_addr (
    .seg_i(cs_i), .ip_i(ip_q), .addr_o(mem_addr_o)
  );

  ifetch_ir #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W), .SLOT_W(LEN_W)) u_ir (
    .clk_i, .rst_ni, .clr_i(clr_c), .wr_i(acc_c), .slot_i(slot_c),
    .byte_i(mem_data_i), .ir_o
  );

  always_comb begin
    mem_req_o = (state_q == ST_OPC) || (state_q == ST_OPR && cnt_q < len_c);
    acc_c     = mem_req_o && mem_rdy_i;
    clr_c     = (state_q == ST_IDLE) && !halt_i && !jump_i;
    slot_c    = (state_q == ST_OPC) ? '0 : cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ip_q    <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (halt_i)      state_q <= ST_HALT;
          else if (jump_i) ip_q    <= jump_ip_i;
          else             state_q <= ST_OPC;
        end
        ST_OPC: if (acc_c) begin
          ip_q    <= ip_q + 1'b1;
          cnt_q   <= LEN_W'(1);
          state_q <= ST_OPR;
        end
        ST_OPR: begin
          if (acc_c) begin
            ip_q  <= ip_q + 1'b1;
            cnt_q <= cnt_q + 1'b1;
          end else if (!mem_req_o) begin
            len_q   <= len_c;
            valid_q <= 1'b1;
            state_q <= ST_VALID;
          end
        end
        ST_VALID: if (exec_done_i) state_q <= ST_IDLE;
        ST_HALT:  state_q <= ST_HALT;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign opc_o    = ir_o[IR_W-1 -: BYTE_W];
  assign len_o    = len_q;
  assign ip_o     = ip_q;
  assign valid_o  = valid_q;
  assign halted_o = (state_q == ST_HALT);

  p_ip_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rdy_i) |=> ip_o == IP_W'($past(ip_o) + 1'b1));

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=> mem_req_o && $stable(mem_addr_o));

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_quiet_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VALID) |-> !mem_req_o);

  p_jump_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !acc_c) |=> $stable(ip_o));

  p_halt_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && !mem_req_o && $stable(ip_o));

  p_len_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (len_o != '0 && int'(len_o) <= MAX_BYTES));

  p_tail_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && int'(len_o) < MAX_BYTES) |-> ir_o[BYTE_W-1:0] == '0);
endmodule

// File: tb/sim_ifetch_seq.sv
module sim_ifetch_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cs;
  logic        jump, halt, done, rdy;
  logic [15:0] jump_ip;
  logic [7:0]  data, opc;
  logic [2:0]  len_tab, len;
  logic        req, valid, halted;
  logic [19:0] addr;
  logic [47:0] ir;
  logic [15:0] ip;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] exp_ip;
  bit noise;
  int stall_pct;

  always #10 clk = ~clk;

  ifetch_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .jump_i(jump), .jump_ip_i(jump_ip),
    .halt_i(halt), .exec_done_i(done), .mem_req_o(req), .mem_addr_o(addr),
    .mem_rdy_i(rdy), .mem_data_i(data), .opc_o(opc), .len_i(len_tab),
    .ir_o(ir), .len_o(len), .ip_o(ip), .valid_o(valid), .halted_o(halted)
  );

  // length table: low three opcode bits
  assign len_tab = opc[2:0];

  function automatic logic [7:0] mem_byte(logic [19:0] a);
    logic [19:0] h;
    if (a == 20'h13C08) return 8'h23;
    h = (a * 20'd40503) ^ (a >> 7);
    return h[7:0] ^ h[15:8] ^ {4'h0, h[19:16]};
  endfunction

  function automatic int clamp_len(logic [2:0] v);
    if (v == 3'd0) return 1;
    if (v == 3'd7) return 6;
    return int'(v);
  endfunction

  function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
    return ({4'h0, s} << 4) + {4'h0, o};
  endfunction

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_instr(output int got_len);
    logic [47:0] exp_ir = '0;
    int n = 0;
    int exp_len = 6;
    forever begin
      if (valid) break;
      if (req) begin
        chk(addr == phys(cs, exp_ip), "R2/R7/R9 addr", addr, phys(cs, exp_ip));
        chk(n == 0 || n < exp_len, "R4 overfetch", n, exp_len);
        if (noise) begin
          jump = 1'b1;
          jump_ip = 16'($urandom);
        end
        if (int'($urandom % 100) < stall_pct) rdy = 1'b0;
        else begin
          rdy  = 1'b1;
          data = mem_byte(addr);
          if (n == 0) exp_len = clamp_len(data[2:0]);
          exp_ir[47-8*n -: 8] = data;
          n++;
          exp_ip++;
        end
      end else rdy = 1'b0;
      @(negedge clk);
    end
    rdy  = 1'b0;
    jump = 1'b0;
    chk(ir == exp_ir, "R3/R5 ir", ir, exp_ir);
    chk(int'(len) == exp_len && n == exp_len, "R4 len", len, exp_len);
    chk(ip == exp_ip, "R6 ip", ip, exp_ip);
    chk(!req, "R8 req in valid", req, 0);
    got_len = n;
  endtask

  // wait, release, return with state idle at a negedge
  task automatic finish(int idle_wait, bit do_jump, logic [15:0] new_ip, logic [15:0] new_cs);
    @(negedge clk);
    chk(!valid, "R8 pulse width", valid, 0);
    for (int i = 0; i < idle_wait; i++) begin
      chk(!req, "R8 wait quiet", req, 0);
      @(negedge clk);
    end
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    cs   = new_cs;
    if (do_jump) begin
      jump = 1'b1;
      jump_ip = new_ip;
      @(negedge clk);
      jump = 1'b0;
      exp_ip = new_ip;
      chk(ip == new_ip && !req, "R9 idle jump", ip, new_ip);
    end
  endtask

  initial begin
    int l;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; cs = 16'h1000; jump = 0; halt = 0; done = 0; rdy = 0;
    jump_ip = '0; data = '0; noise = 0; stall_pct = 0; exp_ip = '0;
    repeat (3) @(negedge clk);
    chk(!req && !valid && !halted, "R1 ctrl", {req, valid, halted}, 0);
    chk(ip == 16'h0 && ir == 48'h0, "R1 regs", {ip, ir}, 0);
    rst_n = 1'b1;

    run_instr(l);
    finish(2, 1'b1, 16'h3C08, 16'h1000);
    run_instr(l);
    chk(l == 3 && ip == 16'h3C0B, "R3 example", {l, ip}, {32'd3, 16'h3C0B});

    for (int i = 0; i < 60; i++) begin
      bit j = ($urandom % 4) == 0;
      finish(int'($urandom % 4), j, 16'($urandom), (($urandom % 3) == 0) ? 16'($urandom) : cs);
      noise     = ($urandom % 3) == 0;
      stall_pct = int'($urandom % 60);
      run_instr(l);
    end
    noise = 0;

    finish(0, 1'b1, 16'hFFFD, 16'hFFFF);
    for (int i = 0; i < 4; i++) begin
      stall_pct = 30;
      run_instr(l);
      finish(1, 1'b0, 16'h0, 16'hFFFF);
    end
    chk(exp_ip < 16'h0020, "R6 wrap reached", exp_ip, 16'h0020);

    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    for (int i = 0; i < 20; i++) begin
      chk(halted && !req && ip == exp_ip, "R10 halted", {halted, req, ip}, {2'b10, exp_ip});
      if (i == 5) done = 1'b1;
      if (i == 8) begin jump = 1'b1; jump_ip = 16'h1234; end
      @(negedge clk);
    end
    done = 0; jump = 0;
    chk(halted && ip == exp_ip, "R10 after inputs", ip, exp_ip);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule